// File: doc/BRIEF.md
# Bus Slave Response Legality Monitor

This block sits beside one slave on a pipelined on-chip bus and watches only the protocol-level control wires. From the bus side it sees the select, the bus-ready input and the two-bit transfer type. From the slave side it sees the ready, the two-bit response and the split-release vector. Address, data, burst and size values never enter it. Each clock it moves a specification state machine one step. The machine has six normal states and two terminal outcomes: a violation outcome for an illegal slave answer to a legal input sequence, and a don't-care outcome for an input sequence a master must never produce.

Every normal state defines a successor for every combination of the observed inputs, so no case is left open. When the monitor fails, it keeps the code of the normal state it was in and the cycle index of the failure, which points the debugging straight at the phase that went wrong. A bitmap records which normal states the traffic has reached, and a completion flag rises once all six have been seen.

Top module: `slave_resp_auditor`

## Requirements
- R1: While reset is held, the violation and don't-care flags are low, the failing-state and failing-cycle outputs are zero, the visited bitmap is 6'b000001 (only the start state, code 0) and the coverage flag is low.
- R2: In the start state (code 0), the IDLE/BUSY data-phase state (code 1) and the post-error state (code 5), any answer other than ready high with OKAY (resp 2'b00) is a violation. This includes a wait state given to an IDLE (trans 2'b00) or BUSY (trans 2'b01) transfer.
- R3: An address phase is accepted only when select and bus-ready input are both high. An accepted SEQ (trans 2'b11) from the start state leads to don't-care. An accepted SEQ after any earlier transfer is legal. IDLE/BUSY lead to code 1, and NONSEQ (2'b10) or SEQ lead to the data state (code 2).
- R4: An ERROR (resp 2'b01) must span two cycles: ready low, then ready high. ERROR with ready high in the data or wait state (codes 2, 3) is a violation from that state. After a first ERROR cycle (state code 4), anything but ready high with ERROR is a violation from code 4.
- R5: If a NONSEQ or SEQ address phase is accepted during the second ERROR cycle, the monitor goes to don't-care. An IDLE accepted in that cycle, or no accepted phase at all, leads to the post-error state.
- R6: A RETRY (2'b10) or SPLIT (2'b11) response, or any set bit on the split-release vector, is a violation.
- R7: In a NONSEQ/SEQ data phase, ready low with OKAY moves to the wait state (code 3). Any number of such cycles is legal.
- R8: Violation and don't-care are held until reset. If one cycle both carries an illegal answer and applies a forbidden input, violation wins.
- R9: On a violation, the failing-state output holds the code of the normal state in which it occurred. The failing-cycle output holds the index of that clock edge, where the first edge after reset release is index 0. Both stay fixed afterwards.
- R10: Bit i of the visited bitmap is set at the edge that enters normal state i and is never cleared. The coverage flag is high exactly when all six bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Slave select from the decoder |
| bus_rdy_in | input | 1 | Bus-ready seen by the slave |
| bus_trans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| slv_ready | input | 1 | Ready driven by the slave |
| slv_resp | input | 2 | Response: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |
| slv_split | input | SPLIT_W | Split-release vector from the slave |
| viol_o | output | 1 | Violation outcome reached |
| dc_o | output | 1 | Don't-care outcome reached |
| fail_state_o | output | 3 | Normal-state code at the violation |
| fail_cycle_o | output | CYC_W | Cycle index of the violation |
| visited_o | output | 6 | Normal states reached so far |
| cov_done_o | output | 1 | All normal states reached |

## Verification
Every result is registered. The flags, failing-state and failing-cycle outputs and the bitmap all reflect the inputs of a cycle at the rising edge that ends that cycle, so each is due exactly one edge after its stimulus. The bench drives a cycle's inputs at the falling edge and queues the expected outcome with it. The monitor pops and compares that item shortly after the next rising edge, so each comparison sees the first edge that could change the result. Failure indices are counted by the bench from reset release, with the one idle cycle between release and the first driven cycle counted as index 0.

// File: rtl/rspchk_pkg.sv
`timescale 1ns/1ps
package rspchk_pkg;

  localparam int NORM_STATES = 6;
  localparam int ST_W        = 3;

  typedef enum logic [ST_W-1:0] {
    ST_ORIG = 3'd0,
    ST_IDLE = 3'd1,
    ST_DATA = 3'd2,
    ST_WAIT = 3'd3,
    ST_ERRA = 3'd4,
    ST_ERRB = 3'd5,
    ST_VIO  = 3'd6,
    ST_DC   = 3'd7
  } chk_state_e;

  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_BUSY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  localparam logic [1:0] RS_OKAY  = 2'b00;
  localparam logic [1:0] RS_ERROR = 2'b01;
  localparam logic [1:0] RS_RETRY = 2'b10;
  localparam logic [1:0] RS_SPLIT = 2'b11;

  typedef struct packed {
    logic       bad;
    logic       dc;
    chk_state_e nxt;
  } verdict_t;

  function automatic logic is_absorbing(chk_state_e s);
    return (s == ST_VIO) || (s == ST_DC);
  endfunction

  function automatic logic quiet_ok(logic rdy, logic [1:0] resp);
    return rdy && (resp == RS_OKAY);
  endfunction

  // Successor after a cycle in which the slave completed its phase.
  function automatic verdict_t addr_phase(logic acc, logic [1:0] tr, logic first);
    verdict_t v;
    v.bad = 1'b0;
    v.dc  = 1'b0;
    v.nxt = ST_ORIG;
    if (acc) begin
      case (tr)
        TR_IDLE, TR_BUSY: v.nxt = ST_IDLE;
        TR_NSEQ:          v.nxt = ST_DATA;
        default: begin
          if (first) v.dc = 1'b1;
          v.nxt = ST_DATA;
        end
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/rspchk_judge.sv
`timescale 1ns/1ps
module rspchk_judge
  import rspchk_pkg::*;
(
  input  chk_state_e cur,
  input  logic       acc,
  input  logic [1:0] trans,
  input  logic       s_rdy,
  input  logic [1:0] resp,
  input  logic       split_any,
  output verdict_t   vd
);

  verdict_t raw;

  always_comb begin
    raw.bad = 1'b0;
    raw.dc  = 1'b0;
    raw.nxt = cur;
    unique case (cur)
      ST_ORIG, ST_IDLE, ST_ERRB: begin
        if (!quiet_ok(s_rdy, resp)) raw.bad = 1'b1;
        else                        raw = addr_phase(acc, trans, cur == ST_ORIG);
      end
      ST_DATA, ST_WAIT: begin
        if (resp == RS_RETRY || resp == RS_SPLIT) begin
          raw.bad = 1'b1;
        end else if (resp == RS_OKAY) begin
          if (s_rdy) raw = addr_phase(acc, trans, 1'b0);
          else       raw.nxt = ST_WAIT;
        end else if (s_rdy) begin
          raw.bad = 1'b1;
        end else begin
          raw.nxt = ST_ERRA;
        end
      end
      ST_ERRA: begin
        if (!(s_rdy && resp == RS_ERROR)) raw.bad = 1'b1;
        else if (acc && trans[1])         raw.dc  = 1'b1;
        else                              raw.nxt = ST_ERRB;
      end
      default: ;
    endcase
    if (split_any && !is_absorbing(cur)) raw.bad = 1'b1;

    vd = raw;
    if (raw.bad) begin
      vd.dc  = 1'b0;
      vd.nxt = ST_VIO;
    end else if (raw.dc) begin
      vd.nxt = ST_DC;
    end
  end

endmodule

// File: rtl/rspchk_fsm.sv
`timescale 1ns/1ps
module rspchk_fsm
  import rspchk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  chk_state_e nxt,
  output chk_state_e cur
);

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= ST_ORIG;
    else        cur <= nxt;
  end

endmodule

// File: rtl/rspchk_record.sv
`timescale 1ns/1ps
module rspchk_record
  import rspchk_pkg::*;
#(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chk_state_e       cur,
  input  chk_state_e       nxt,
  output logic [ST_W-1:0]  fail_state,
  output logic [CYC_W-1:0] fail_cycle
);

  localparam logic [CYC_W-1:0] CYC_MAX = '1;
  localparam logic [CYC_W-1:0] CYC_ONE = 1;

  logic [CYC_W-1:0] cyc_q;
  logic             live;
  logic             fail_evt;

  assign live     = !is_absorbing(cur);
  assign fail_evt = live && (nxt == ST_VIO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q      <= '0;
      fail_state <= '0;
      fail_cycle <= '0;
    end else begin
      if (live && cyc_q != CYC_MAX) cyc_q <= cyc_q + CYC_ONE;
      if (fail_evt) begin
        fail_state <= cur;
        fail_cycle <= cyc_q;
      end
    end
  end

endmodule

// File: rtl/rspchk_cover.sv
`timescale 1ns/1ps
module rspchk_cover
  import rspchk_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  chk_state_e             nxt,
  output logic [NORM_STATES-1:0] visited,
  output logic                   all_seen
);

  localparam logic [NORM_STATES-1:0] VIS_INIT = 1;

  logic [NORM_STATES-1:0] hit;

  for (genvar i = 0; i < NORM_STATES; i++) begin : g_hit
    assign hit[i] = (nxt == chk_state_e'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) visited <= VIS_INIT;
    else        visited <= visited | hit;
  end

  assign all_seen = &visited;

endmodule

// File: rtl/slave_resp_auditor.sv
`timescale 1ns/1ps
module slave_resp_auditor
  import rspchk_pkg::*;
#(
  parameter int SPLIT_W = 16,
  parameter int CYC_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_rdy_in,
  input  logic [1:0]             bus_trans,
  input  logic                   slv_ready,
  input  logic [1:0]             slv_resp,
  input  logic [SPLIT_W-1:0]     slv_split,
  output logic                   viol_o,
  output logic                   dc_o,
  output logic [ST_W-1:0]        fail_state_o,
  output logic [CYC_W-1:0]       fail_cycle_o,
  output logic [NORM_STATES-1:0] visited_o,
  output logic                   cov_done_o
);

  chk_state_e cur_state;
  verdict_t   step_vd;
  logic       addr_acc;
  logic       split_any;

  assign addr_acc  = bus_sel & bus_rdy_in;
  assign split_any = |slv_split;

  rspchk_judge u_judge (
    .cur       (cur_state),
    .acc       (addr_acc),
    .trans     (bus_trans),
    .s_rdy     (slv_ready),
    .resp      (slv_resp),
    .split_any (split_any),
    .vd        (step_vd)
  );

  rspchk_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt   (step_vd.nxt),
    .cur   (cur_state)
  );

  rspchk_record #(.CYC_W(CYC_W)) u_rec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur        (cur_state),
    .nxt        (step_vd.nxt),
    .fail_state (fail_state_o),
    .fail_cycle (fail_cycle_o)
  );

  rspchk_cover u_cov (
    .clk      (clk),
    .rst_n    (rst_n),
    .nxt      (step_vd.nxt),
    .visited  (visited_o),
    .all_seen (cov_done_o)
  );

  assign viol_o = (cur_state == ST_VIO);
  assign dc_o   = (cur_state == ST_DC);

endmodule

// File: rtl/slave_resp_auditor_chk.sv
`timescale 1ns/1ps
module slave_resp_auditor_chk #(
  parameter int SPLIT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         cur_state,
  input logic               slv_ready,
  input logic [1:0]         slv_resp,
  input logic [SPLIT_W-1:0] slv_split,
  input logic               viol_o,
  input logic               dc_o,
  input logic [2:0]         fail_state_o,
  input logic [5:0]         visited_o,
  input logic               cov_done_o
);

  // R2
  idle_wait_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 3'd1 && !slv_ready) |=> viol_o);

  // R4
  short_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 3'd2 && slv_resp == 2'b01 && slv_ready) |=> viol_o);

  // R6
  split_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|slv_split) && !dc_o) |=> viol_o);

  // R8
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |=> viol_o);

  // R8
  dc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dc_o |=> dc_o);

  // R8
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(viol_o && dc_o));

  // R9
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_o) |-> (fail_state_o < 3'd6));

  // R9
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |=> $stable(fail_state_o));

  // R10
  visit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((visited_o & $past(visited_o)) == $past(visited_o)));

  // R10
  cov_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cov_done_o |=> cov_done_o);

endmodule

bind slave_resp_auditor slave_resp_auditor_chk #(.SPLIT_W(SPLIT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cur_state    (cur_state),
  .slv_ready    (slv_ready),
  .slv_resp     (slv_resp),
  .slv_split    (slv_split),
  .viol_o       (viol_o),
  .dc_o         (dc_o),
  .fail_state_o (fail_state_o),
  .visited_o    (visited_o),
  .cov_done_o   (cov_done_o)
);

// File: tb/slave_resp_auditor_tb.sv
`timescale 1ns/1ps
module slave_resp_auditor_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        rin = 1'b1;
  logic [1:0]  trans = 2'b00;
  logic        srdy = 1'b1;
  logic [1:0]  resp = 2'b00;
  logic [15:0] split = '0;
  logic        viol, dc, cov;
  logic [2:0]  fstate;
  logic [15:0] fcyc;
  logic [5:0]  vis;

  always #2.5 clk = ~clk;

  slave_resp_auditor u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_rdy_in(rin),
    .bus_trans(trans), .slv_ready(srdy), .slv_resp(resp), .slv_split(split),
    .viol_o(viol), .dc_o(dc), .fail_state_o(fstate), .fail_cycle_o(fcyc),
    .visited_o(vis), .cov_done_o(cov)
  );

  typedef struct {
    logic        viol;
    logic        dc;
    logic        chk_fail;
    logic [2:0]  fs;
    logic [15:0] fc;
    logic        chk_vis;
    logic [5:0]  vis;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  nx;
  int    n_cmp = 0;
  int    n_bad = 0;
  int    stepn = 0;
  bit    done  = 0;

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic void want(logic v, logic d);
    nx.viol = v; nx.dc = d; nx.chk_fail = 0; nx.fs = '0; nx.fc = '0;
    nx.chk_vis = 0; nx.vis = '0;
  endfunction

  function automatic void want_fail(logic [2:0] s);
    nx.chk_fail = 1; nx.fs = s; nx.fc = 16'(stepn + 1);
  endfunction

  function automatic void want_vis(logic [5:0] v);
    nx.chk_vis = 1; nx.vis = v;
  endfunction

  // Driver: applies one cycle of inputs and queues its expected outcome.
  task automatic cyc(logic s, logic r, logic [1:0] t, logic sr, logic [1:0] rs,
                     logic [15:0] sp, string tag);
    @(negedge clk);
    sel = s; rin = r; trans = t; srdy = sr; resp = rs; split = sp;
    stepn++;
    exp_q.push_back(nx);
    tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; sel = 0; rin = 1; trans = 2'b00; srdy = 1; resp = 2'b00; split = '0;
    repeat (2) @(negedge clk);
    cmp("R1", "viol", viol, 0);
    cmp("R1", "dc", dc, 0);
    cmp("R1", "visited", vis, 6'b000001);
    cmp("R1", "cov", cov, 0);
    cmp("R1", "fail_state", fstate, 0);
    cmp("R1", "fail_cycle", fcyc, 0);
    rst_n = 1;
    stepn = 0;
  endtask

  // Monitor: compares each queued item just after the edge that resolves it.
  always @(posedge clk) begin
    exp_t  e;
    string t;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp(t, "viol", viol, e.viol);
      cmp(t, "dc", dc, e.dc);
      if (e.chk_fail) begin
        cmp(t, "fail_state", fstate, e.fs);
        cmp(t, "fail_cycle", fcyc, e.fc);
      end
      if (e.chk_vis) begin
        cmp(t, "visited", vis, e.vis);
        cmp(t, "cov", cov, &e.vis);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // Legal traffic through every normal state: R3, R7, R10
    do_reset();
    want(0,0); cyc(1,1,2'b10, 1,2'b00, 0, "R3");
    want(0,0); cyc(1,1,2'b11, 1,2'b00, 0, "R3");
    want(0,0); cyc(1,1,2'b11, 0,2'b00, 0, "R7");
    want(0,0); cyc(1,1,2'b11, 0,2'b00, 0, "R7");
    want(0,0); want_vis(6'b001111); cyc(1,1,2'b00, 1,2'b00, 0, "R10");
    want(0,0); cyc(1,1,2'b01, 1,2'b00, 0, "R2");
    want(0,0); cyc(0,1,2'b00, 1,2'b00, 0, "R2");
    want(0,0); cyc(1,1,2'b10, 1,2'b00, 0, "R3");
    want(0,0); cyc(0,1,2'b00, 0,2'b01, 0, "R4");
    want(0,0); cyc(1,1,2'b00, 1,2'b01, 0, "R5");
    want(0,0); want_vis(6'b111111); cyc(0,1,2'b00, 1,2'b00, 0, "R10");
    want(0,0); cyc(1,0,2'b11, 1,2'b00, 0, "R3");
    want(0,0); cyc(0,1,2'b11, 1,2'b00, 0, "R3");

    // Wait state on an IDLE transfer, then stickiness: R2, R8, R9
    do_reset();
    want(0,0); cyc(1,1,2'b00, 1,2'b00, 0, "R2");
    want(1,0); want_fail(3'd1); want_vis(6'b000011); cyc(0,1,2'b00, 0,2'b00, 0, "R2");
    want(1,0); nx.chk_fail = 1; nx.fs = 3'd1; nx.fc = 16'd2;
    cyc(0,1,2'b00, 1,2'b00, 0, "R8");

    // ERROR on a BUSY transfer: R2
    do_reset();
    want(0,0); cyc(1,1,2'b01, 1,2'b00, 0, "R2");
    want(1,0); want_fail(3'd1); cyc(0,1,2'b00, 1,2'b01, 0, "R2");

    // First transfer sequential, then a bad answer stays don't-care: R3, R8
    do_reset();
    want(0,1); cyc(1,1,2'b11, 1,2'b00, 0, "R3");
    want(0,1); cyc(0,1,2'b00, 0,2'b01, 0, "R8");

    // Single-cycle ERROR: R4
    do_reset();
    want(0,0); cyc(1,1,2'b10, 1,2'b00, 0, "R4");
    want(1,0); want_fail(3'd2); cyc(0,1,2'b00, 1,2'b01, 0, "R4");

    // Second ERROR cycle missing: R4
    do_reset();
    want(0,0); cyc(1,1,2'b10, 1,2'b00, 0, "R4");
    want(0,0); cyc(0,1,2'b00, 0,2'b01, 0, "R4");
    want(1,0); want_fail(3'd4); cyc(0,1,2'b00, 1,2'b00, 0, "R4");

    // Master continues after ERROR: R5
    do_reset();
    want(0,0); cyc(1,1,2'b10, 1,2'b00, 0, "R5");
    want(0,0); cyc(1,1,2'b10, 0,2'b01, 0, "R5");
    want(0,1); cyc(1,1,2'b10, 1,2'b01, 0, "R5");

    // RETRY response: R6
    do_reset();
    want(0,0); cyc(1,1,2'b10, 1,2'b00, 0, "R6");
    want(1,0); want_fail(3'd2); cyc(0,1,2'b00, 0,2'b10, 0, "R6");

    // Split-release bit: R6
    do_reset();
    want(1,0); want_fail(3'd0); cyc(0,1,2'b00, 1,2'b00, 16'h0004, "R6");

    // Illegal answer and forbidden input together: R8
    do_reset();
    want(1,0); want_fail(3'd0); cyc(1,1,2'b11, 0,2'b00, 0, "R8");

    // Wait then two-cycle ERROR, legal recovery: R4, R7, R10
    do_reset();
    want(0,0); cyc(1,1,2'b10, 1,2'b00, 0, "R7");
    want(0,0); cyc(1,1,2'b10, 0,2'b00, 0, "R7");
    want(0,0); cyc(1,1,2'b10, 0,2'b01, 0, "R4");
    want(0,0); cyc(0,1,2'b00, 1,2'b01, 0, "R4");
    want(0,0); want_vis(6'b111101); cyc(0,1,2'b00, 1,2'b00, 0, "R10");

    // Wait state in the post-error state: R2, R9
    do_reset();
    want(0,0); cyc(1,1,2'b10, 1,2'b00, 0, "R2");
    want(0,0); cyc(0,1,2'b00, 0,2'b01, 0, "R2");
    want(0,0); cyc(1,1,2'b00, 1,2'b01, 0, "R2");
    want(1,0); want_fail(3'd5); cyc(0,1,2'b00, 0,2'b00, 0, "R9");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule